// File: doc/BRIEF.md
# Nibble-Bus Multiply/Divide Unit

This block is an arithmetic helper that hangs on a 4-bit-wide processor data bus. It computes either the unsigned product of two 8-bit values or the unsigned quotient and remainder of a 16-bit value divided by an 8-bit value. Software loads each 8-bit operand as two nibble writes. It then writes the control nibble to choose the operation and start it. The results are written back over the operand registers, and software reads them the same way, one nibble at a time.

The operation takes a fixed number of clocks, set by a parameter with a default of 10. While it runs, the mode bit reads as busy. A zero flag reports whether the result was zero. A division whose quotient would not fit in 8 bits leaves the dividend untouched. An enable bit gates the engine, so when it is cleared the arithmetic stops advancing.

Top module: `muldiv_nibble`

## Requirements
- R1: Each 8-bit register takes two nibble addresses, and the lower address holds bits 3:0. The source register is at addresses 0 and 1, the result-low register at 2 and 3, and the result-high register at 4 and 5. The control nibble is at 6. The enable bit is bit 0 of address 7. A read returns the nibble last written, and unused bits read 0.
- R2: A write to address 6 starts an operation. Bit 0 of the written value selects the operation: 0 for multiply, 1 for divide. Control bit 0 then reads 1 for exactly 10 enabled clock edges, starting after the start edge. It reads 0 again, with the results in place, after the 10th edge.
- R3: Multiply returns the product of the source and result-low registers. The product's low byte goes to result-low and its high byte to result-high. The prior content of result-high has no effect.
- R4: Divide takes the dividend from {result-high, result-low} and the divisor from the source register. The quotient is written to result-low and the remainder to result-high.
- R5: A divide is an overflow when the divisor is 0 or when result-high is greater than or equal to the divisor. On an overflow, both result registers keep the dividend.
- R6: The zero flag is control bit 1. It is set when the product, or for a divide the quotient, is 0. An overflow clears it. The flag changes only when an operation completes, and bus writes never change it.
- R7: When the enable bit is 0, a started operation stays busy and its results are not written. Once the bit is set, the operation finishes 10 edges later.
- R8: A write to address 6 while busy is ignored. The running operation keeps its mode and its completion time.
- R9: The source register keeps its value across operations until software writes it again.
- R10: After reset, the control nibble, the enable bit and all data registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the nibble at addr |
| addr | input | 3 | Nibble address |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for the nibble at addr (combinational) |

## Verification
The bench goes after the divide overflow boundary: a divisor of zero, and a high byte exactly equal to the divisor. A design that compared with strict greater-than would write back a wrapped quotient instead of keeping the dividend. Results of zero from both operations test whether the zero flag looks at the full product and at the quotient only. Two further tests cover a start write during a busy run and a start while disabled. A design that restarted or switched mode on the second write would show the wrong busy length or wrong result. A design that ignored the enable bit would finish while still frozen. The busy window is sampled on the 9th and 10th edge after the start, which catches any off-by-one in the latency.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    // Bus and arithmetic defaults shared by the unit and its checker.
    localparam int NIB_W_DEF   = 4;
    localparam int DATA_W_DEF  = 8;
    localparam int LATENCY_DEF = 10;

    // Register groups in nibble-address order.
    typedef enum logic [1:0] {
        GRP_SRC  = 2'd0,
        GRP_RLO  = 2'd1,
        GRP_RHI  = 2'd2,
        GRP_CTRL = 2'd3
    } reg_grp_e;

    // Control nibble bit positions.
    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_ZERO_BIT = 1;
endpackage

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
    parameter int DW  = 8,
    parameter int LAT = 10   // must exceed DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic          div_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          wb_o,
    output logic          zero_o,
    output logic [DW-1:0] res_lo_o,
    output logic [DW-1:0] res_hi_o
);
    localparam int STEPS = DW;
    localparam int CW    = $clog2(LAT);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          div;
        logic          ovf;
        logic [DW:0]   acc;   // partial product high half / running remainder
        logic [DW-1:0] q;     // multiplier bits out / quotient bits in
        logic [DW-1:0] m;     // multiplicand-side source / divisor
    } eng_t;

    eng_t        s_d, s_q;
    logic [DW:0] sum_w;
    logic [DW:0] trial_w;
    logic        fits_w;

    always_comb begin
        s_d     = s_q;
        done_o  = 1'b0;
        sum_w   = {1'b0, s_q.acc[DW-1:0]} + (s_q.q[0] ? {1'b0, s_q.m} : '0);
        trial_w = {s_q.acc[DW-1:0], s_q.q[DW-1]};
        fits_w  = (trial_w >= {1'b0, s_q.m});
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.div  = div_i;
                s_d.m    = src_i;
                s_d.q    = lo_i;
                if (div_i) begin
                    s_d.ovf = (src_i == '0) || (hi_i >= src_i);
                    s_d.acc = {1'b0, hi_i};
                end else begin
                    s_d.ovf = 1'b0;
                    s_d.acc = '0;
                end
            end
        end else if (en_i) begin
            if (s_q.cnt == CW'(LAT-1)) begin
                done_o   = 1'b1;
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt < CW'(STEPS) && !s_q.ovf) begin
                    if (s_q.div) begin
                        s_d.acc = fits_w ? (trial_w - {1'b0, s_q.m}) : trial_w;
                        s_d.q   = {s_q.q[DW-2:0], fits_w};
                    end else begin
                        s_d.acc = {1'b0, sum_w[DW:1]};
                        s_d.q   = {sum_w[0], s_q.q[DW-1:1]};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o   = s_q.busy;
    assign wb_o     = !s_q.ovf;
    assign res_lo_o = s_q.q;
    assign res_hi_o = s_q.acc[DW-1:0];
    assign zero_o   = s_q.div ? (s_q.q == '0) : ({s_q.acc[DW-1:0], s_q.q} == '0);
endmodule

// File: rtl/muldiv_regs.sv
module muldiv_regs
    import muldiv_pkg::*;
#(
    parameter int NW = 4,
    parameter int DW = 8,
    localparam int NPN = DW / NW,
    localparam int AW  = $clog2(3 * NPN + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NW-1:0] wdata_i,
    output logic [NW-1:0] rdata_o,
    input  logic          busy_i,
    input  logic          done_i,
    input  logic          wb_i,
    input  logic          zero_i,
    input  logic [DW-1:0] res_lo_i,
    input  logic [DW-1:0] res_hi_i,
    output logic          start_o,
    output logic          div_o,
    output logic [DW-1:0] src_o,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic          en_o,
    output logic          zf_o
);
    localparam int CTRL_A = int'(GRP_CTRL) * NPN;
    localparam int EN_A   = CTRL_A + 1;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic          zf;
        logic          en;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int n = 0; n < NPN; n++) begin
            if (wr_en_i && addr_i == AW'(int'(GRP_SRC) * NPN + n)) s_d.src[n*NW +: NW] = wdata_i;
            if (wr_en_i && addr_i == AW'(int'(GRP_RLO) * NPN + n)) s_d.lo[n*NW +: NW]  = wdata_i;
            if (wr_en_i && addr_i == AW'(int'(GRP_RHI) * NPN + n)) s_d.hi[n*NW +: NW]  = wdata_i;
        end
        if (wr_en_i && addr_i == AW'(EN_A)) s_d.en = wdata_i[0];
        // Completion write-back wins over a bus write in the same cycle.
        if (done_i) begin
            s_d.zf = wb_i & zero_i;
            if (wb_i) begin
                s_d.lo = res_lo_i;
                s_d.hi = res_hi_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NPN; n++) begin
            if (addr_i == AW'(int'(GRP_SRC) * NPN + n)) rdata_o = s_q.src[n*NW +: NW];
            if (addr_i == AW'(int'(GRP_RLO) * NPN + n)) rdata_o = s_q.lo[n*NW +: NW];
            if (addr_i == AW'(int'(GRP_RHI) * NPN + n)) rdata_o = s_q.hi[n*NW +: NW];
        end
        if (addr_i == AW'(CTRL_A)) begin
            rdata_o[CTRL_BUSY_BIT] = busy_i;
            rdata_o[CTRL_ZERO_BIT] = s_q.zf;
        end
        if (addr_i == AW'(EN_A)) rdata_o[0] = s_q.en;
    end

    assign start_o = wr_en_i && (addr_i == AW'(CTRL_A)) && !busy_i;
    assign div_o   = wdata_i[CTRL_BUSY_BIT];
    assign src_o   = s_q.src;
    assign lo_o    = s_q.lo;
    assign hi_o    = s_q.hi;
    assign en_o    = s_q.en;
    assign zf_o    = s_q.zf;
endmodule

// File: rtl/muldiv_nibble.sv
module muldiv_nibble
    import muldiv_pkg::*;
#(
    parameter int NIB_W   = NIB_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int LATENCY = LATENCY_DEF,
    localparam int NPN    = DATA_W / NIB_W,
    localparam int ADDR_W = $clog2(3 * NPN + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rdata
);
    logic              eng_busy, eng_done, eng_wb, eng_zero;
    logic [DATA_W-1:0] eng_lo, eng_hi;
    logic              start, is_div, clk_en, zf;
    logic [DATA_W-1:0] src, dlo, dhi;

    muldiv_regs #(.NW(NIB_W), .DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .busy_i   (eng_busy),
        .done_i   (eng_done),
        .wb_i     (eng_wb),
        .zero_i   (eng_zero),
        .res_lo_i (eng_lo),
        .res_hi_i (eng_hi),
        .start_o  (start),
        .div_o    (is_div),
        .src_o    (src),
        .lo_o     (dlo),
        .hi_o     (dhi),
        .en_o     (clk_en),
        .zf_o     (zf)
    );

    muldiv_engine #(.DW(DATA_W), .LAT(LATENCY)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (clk_en),
        .start_i  (start),
        .div_i    (is_div),
        .src_i    (src),
        .lo_i     (dlo),
        .hi_i     (dhi),
        .busy_o   (eng_busy),
        .done_o   (eng_done),
        .wb_o     (eng_wb),
        .zero_o   (eng_zero),
        .res_lo_o (eng_lo),
        .res_hi_o (eng_hi)
    );
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int AW     = 3,
    parameter int DW     = 8,
    parameter int LAT    = 10,
    parameter int CTRL_A = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          clk_en,
    input logic          done,
    input logic          wb,
    input logic          zf,
    input logic [DW-1:0] dlo,
    input logic [DW-1:0] dhi
);
    localparam int CW = $clog2(LAT + 2);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_cnt <= '0;
        else if (!busy)        run_cnt <= '0;
        else if (clk_en)       run_cnt <= run_cnt + 1'b1;
    end

    // R2: busy only begins after a write to the control nibble
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == AW'(CTRL_A)));

    // R2: a run lasts exactly LAT enabled edges
    assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_cnt == CW'(LAT));

    // R5: an overflowing divide leaves both result registers alone
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wb && !wr_en) |=> ($stable(dlo) && $stable(dhi)));

    // R6: the zero flag moves only on completion
    assert_zero_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(zf));

    // R7: a disabled engine stays busy
    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clk_en) |=> busy);
endmodule

bind muldiv_nibble muldiv_checker #(
    .AW(ADDR_W), .DW(DATA_W), .LAT(LATENCY), .CTRL_A(3 * NPN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .busy   (eng_busy),
    .clk_en (clk_en),
    .done   (eng_done),
    .wb     (eng_wb),
    .zf     (zf),
    .dlo    (dlo),
    .dhi    (dhi)
);

// File: tb/sim_muldiv_nibble.sv
`timescale 1ns/100ps
module sim_muldiv_nibble;
    localparam logic [2:0] A_SRC = 3'd0, A_RLO = 3'd2, A_RHI = 3'd4, A_CTRL = 3'd6, A_EN = 3'd7;
    localparam int NVEC = 11;
    // {divide, source, result-low, result-high}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'h0F, 8'h11, 8'h00},
        {1'b0, 8'hFF, 8'hFF, 8'h5A},
        {1'b0, 8'h00, 8'h37, 8'hAA},
        {1'b0, 8'h80, 8'h02, 8'h00},
        {1'b1, 8'h56, 8'h34, 8'h12},
        {1'b1, 8'h00, 8'h34, 8'h12},
        {1'b1, 8'h40, 8'h00, 8'h40},
        {1'b1, 8'h07, 8'h05, 8'h00},
        {1'b1, 8'h80, 8'hFF, 8'h7F},
        {1'b1, 8'h01, 8'hFF, 8'h00},
        {1'b1, 8'h3F, 8'hFF, 8'h3E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    muldiv_nibble u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wr8(input logic [2:0] a, input logic [7:0] v);
        wr(a, v[3:0]);
        wr(a + 3'd1, v[7:4]);
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        logic [3:0] l, h;
        rd(a, l);
        rd(a + 3'd1, h);
        v = {h, l};
    endtask

    // Reference: {hi, lo, zero}
    function automatic logic [16:0] model(input logic dv, input logic [7:0] s, input logic [7:0] lo, input logic [7:0] hi);
        logic [15:0] p;
        if (!dv) begin
            p = 16'(s) * 16'(lo);
            return {p, p == 16'd0};
        end
        if (s == 8'd0 || hi >= s) return {hi, lo, 1'b0};
        p = {hi, lo};
        return {8'(p % 16'(s)), 8'(p / 16'(s)), (p / 16'(s)) == 16'd0};
    endfunction

    // Busy window after a start write that has just returned (1 ns past edge k).
    task automatic busy_window(input string req);
        addr = A_CTRL;
        repeat (9) @(posedge clk);
        #1 check(req, 16'(rdata[0]), 16'd1);
        @(posedge clk);
        #1 check(req, 16'(rdata[0]), 16'd0);
    endtask

    task automatic run_vec(input logic [24:0] v);
        logic [16:0] e;
        logic [7:0] lo, hi;
        logic [3:0] c;
        string tag;
        wr8(A_SRC, v[23:16]);
        wr8(A_RLO, v[15:8]);
        wr8(A_RHI, v[7:0]);
        wr(A_CTRL, {3'b000, v[24]});
        busy_window("R2 busy window");
        e = model(v[24], v[23:16], v[15:8], v[7:0]);
        rd8(A_RLO, lo);
        rd8(A_RHI, hi);
        rd(A_CTRL, c);
        tag = v[24] ? ((v[23:16] == 0 || v[7:0] >= v[23:16]) ? "R5 overflow keeps dividend" : "R4 divide")
                    : "R3 multiply";
        check(tag, {hi, lo}, e[16:1]);
        check("R6 zero flag", 16'(c[1]), 16'(e[0]));
    endtask

    initial begin
        logic [3:0] n;
        logic [7:0] b, lo, hi;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        rd(A_CTRL, n); check("R10 control after reset", 16'(n), 16'd0);
        rd(A_EN, n);   check("R10 enable after reset", 16'(n), 16'd0);
        rd8(A_RLO, b); check("R10 result-low after reset", 16'(b), 16'd0);
        wr(A_EN, 4'h1);
        rd(A_EN, n);   check("R1 enable readback", 16'(n), 16'd1);
        // R1 nibble order
        wr(A_SRC, 4'h5); wr(A_SRC + 3'd1, 4'hA);
        rd(A_SRC, n);        check("R1 source low nibble", 16'(n), 16'h5);
        rd(A_SRC + 3'd1, n); check("R1 source high nibble", 16'(n), 16'hA);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R9: source kept; multiply with old source 0x3F
        wr8(A_RLO, 8'h02);
        wr(A_CTRL, 4'h0);
        busy_window("R2 busy window");
        rd8(A_RLO, lo); rd8(A_RHI, hi);
        check("R9 source retained", {hi, lo}, 16'h007E);
        rd8(A_SRC, b);  check("R9 source readback", 16'(b), 16'h003F);

        // R8: second start during busy is ignored
        wr8(A_SRC, 8'h03); wr8(A_RLO, 8'h04);
        wr(A_CTRL, 4'h0);
        wr(A_CTRL, 4'h1);
        addr = A_CTRL;
        repeat (8) @(posedge clk);
        #1 check("R8 busy kept", 16'(rdata[0]), 16'd1);
        @(posedge clk);
        #1 check("R8 completion time unchanged", 16'(rdata[0]), 16'd0);
        rd8(A_RLO, lo); rd8(A_RHI, hi);
        check("R8 mode unchanged", {hi, lo}, 16'h000C);

        // R6: writing 1 to the zero bit does not set it (starts a nonzero multiply)
        wr(A_CTRL, 4'b0010);
        rd(A_CTRL, n);  check("R6 zero flag not writable", 16'(n[1]), 16'd0);
        repeat (12) @(posedge clk);

        // R7: start while disabled stays frozen
        wr8(A_SRC, 8'h10); wr8(A_RLO, 8'h10);
        wr(A_EN, 4'h0);
        wr(A_CTRL, 4'h0);
        repeat (30) @(posedge clk);
        rd(A_CTRL, n);  check("R7 frozen busy", 16'(n[0]), 16'd1);
        rd8(A_RLO, b);  check("R7 frozen no write-back", 16'(b), 16'h0010);
        wr(A_EN, 4'h1);
        busy_window("R7 resumes after enable");
        rd8(A_RLO, lo); rd8(A_RHI, hi);
        check("R7 result after enable", {hi, lo}, 16'h0100);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule